// File: doc/BRIEF.md
# Eight-Channel Pulse Width Modulator with Pairwise Concatenation

This block produces eight pulse width modulated outputs from eight 8-bit channels. One free-running divider provides clock-enable ticks at every power-of-two rate from divide-by-1 to divide-by-128. Each channel picks one of these tick rates, counts through its period and holds its pin high for the first part of each period. Adjacent channels can be joined into one 16-bit channel. The odd channel of the pair carries the low byte, owns the enable and the clock choice, and drives the joined waveform. The even pin of the pair stays low.

Software drives the block through a plain register bus with an address, write data, a write strobe and registered read data. When a channel is enabled, its waveform starts only on the next tick of its chosen rate. Period and duty changes take effect at a period boundary. When every enable bit is clear, the divider stops and returns to zero.

Top module: `pwm_mux8`

## Requirements
- R1: After reset, every register reads 0 and all eight output pins are low.
- R2: The two top address bits select a bank and the low three bits select an entry. Bank 0 holds the enable register at entry 0, where bit c enables channel c, and the concatenation register at entry 1, where bit p joins channels 2p and 2p+1. Bank 1 holds the clock select for each channel, bank 2 the period and bank 3 the duty. Every register reads back what was written. Other bank-0 entries read 0. Read data is registered and appears one clock after the address.
- R3: A clock select value s in the low three bits makes the channel advance once every 2^s clocks.
- R4: An enabled channel counts 0 up to period-1, advancing one step per tick, and its pin is high while the count is below the duty. A period of 0 means 256 ticks. A duty at or above the period gives a constant high. The pin is registered and lags the count by one clock.
- R5: A disabled channel holds its pin low from the second clock after its enable bit clears.
- R6: Setting an enable bit starts the waveform only at the next tick of that channel's rate. With the divider idle and select 7, the pin first goes high 129 clocks after the write edge when the duty is at least the period.
- R7: While all eight enable bits are 0, the divider stays at zero, so the R6 latency is the same after any idle time.
- R8: A joined pair uses the odd channel's enable bit and clock select. Its 16-bit period is {even period, odd period} and its 16-bit duty is {even duty, odd duty}. The waveform appears on the odd pin.
- R9: In a joined pair the even pin is held low, and the even enable bit has no effect.
- R10: Period and duty writes to a running channel take effect only when the current period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register address: bank in bits 4:3, entry in bits 2:0 |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_rdata | output | 8 | Registered read data |
| pwm_out | output | 8 | PWM pins, bit c for channel c |

## Verification
The bench sweeps period and duty over several tick rates, including a duty of zero, a duty equal to the period, a duty above the period and the 256-tick period. It counts high clocks over whole periods, so a count or compare that is off by one, or a wrong divide ratio, changes the total. It measures the start-up delay exactly, once from a fresh start and again after an idle gap. A divider that kept running while idle, or an enable that bypassed the tick, would give a different delay. It changes the duty partway through a period, which catches shadow loading that happens too early. It also runs a joined pair with a different clock select on the even side, so a design that used the wrong byte order, the wrong enable or the wrong clock select would show it.

// File: rtl/pwm_mux_pkg.sv
package pwm_mux_pkg;
  typedef enum logic [1:0] {
    BK_CTRL = 2'd0,
    BK_CLK  = 2'd1,
    BK_PER  = 2'd2,
    BK_DUTY = 2'd3
  } bank_e;

  localparam int CTRL_EN_IDX  = 0;
  localparam int CTRL_CAT_IDX = 1;
endpackage

// File: rtl/pwm_mux_regs.sv
module pwm_mux_regs
  import pwm_mux_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 8,
  parameter int PSW = 3,
  localparam int CHW = $clog2(NCH),
  localparam int AW  = CHW + 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [AW-1:0]                 addr,
  input  logic [CW-1:0]                 wdata,
  input  logic                          we,
  output logic [CW-1:0]                 rdata,
  output logic [NCH-1:0]                en_q,
  output logic [NCH/2-1:0]              cat_q,
  output logic [NCH-1:0][PSW-1:0]       sel_o,
  output logic [NCH-1:0][CW-1:0]        per_q,
  output logic [NCH-1:0][CW-1:0]        duty_q
);
  bank_e                  bk;
  logic [CHW-1:0]         idx;
  logic [NCH-1:0][CW-1:0] sel_q;
  logic [CW-1:0]          rd_mux;

  assign bk  = bank_e'(addr[AW-1:CHW]);
  assign idx = addr[CHW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      cat_q  <= '0;
      sel_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else if (we) begin
      case (bk)
        BK_CTRL: begin
          if (idx == CHW'(CTRL_EN_IDX))  en_q  <= wdata[NCH-1:0];
          if (idx == CHW'(CTRL_CAT_IDX)) cat_q <= wdata[NCH/2-1:0];
        end
        BK_CLK:  sel_q[idx]  <= wdata;
        BK_PER:  per_q[idx]  <= wdata;
        default: duty_q[idx] <= wdata;
      endcase
    end
  end

  always_comb begin
    case (bk)
      BK_CTRL: begin
        if (idx == CHW'(CTRL_EN_IDX))       rd_mux = CW'(en_q);
        else if (idx == CHW'(CTRL_CAT_IDX)) rd_mux = CW'(cat_q);
        else                                rd_mux = '0;
      end
      BK_CLK:  rd_mux = sel_q[idx];
      BK_PER:  rd_mux = per_q[idx];
      default: rd_mux = duty_q[idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign sel_o[c] = sel_q[c][PSW-1:0];
  end
endmodule

// File: rtl/pwm_mux_prescale.sv
module pwm_mux_prescale #(
  parameter int PSW = 3,
  localparam int NT  = 2 ** PSW,
  localparam int DVW = NT - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [NT-1:0] tick
);
  logic [DVW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  assign tick[0] = run;
  for (genvar k = 1; k < NT; k++) begin : g_tick
    assign tick[k] = run && (&div_q[k-1:0]);
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !run |=> (div_q == '0)); // R7
endmodule

// File: rtl/pwm_mux_chan.sv
module pwm_mux_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] per_in,
  input  logic [W-1:0] duty_in,
  output logic         pwm_o
);
  logic         act;
  logic [W-1:0] cnt;
  logic [W-1:0] per_s;
  logic [W-1:0] duty_s;
  logic         wrap;

  assign wrap = (cnt + W'(1)) == per_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      cnt    <= '0;
      per_s  <= '0;
      duty_s <= '0;
      pwm_o  <= 1'b0;
    end else begin
      pwm_o <= act && (cnt < duty_s);
      if (!en) begin
        act    <= 1'b0;
        cnt    <= '0;
        per_s  <= per_in;
        duty_s <= duty_in;
      end else if (tick) begin
        if (!act || wrap) begin
          act    <= 1'b1;
          cnt    <= '0;
          per_s  <= per_in;
          duty_s <= duty_in;
        end else begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(en)) |=> !pwm_o); // R5

  AST_WAIT_TICK: assert property (@(posedge clk) disable iff (rst)
    (en && !act && !tick) |=> !act); // R6

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    act |-> (per_s == '0 || cnt < per_s)); // R4
endmodule

// File: rtl/pwm_mux_pair.sv
module pwm_mux_pair #(
  parameter int CW  = 8,
  parameter int PSW = 3,
  localparam int NT = 2 ** PSW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cat,
  input  logic           en_hi,
  input  logic           en_lo,
  input  logic [PSW-1:0] sel_hi,
  input  logic [PSW-1:0] sel_lo,
  input  logic [CW-1:0]  per_hi,
  input  logic [CW-1:0]  per_lo,
  input  logic [CW-1:0]  duty_hi,
  input  logic [CW-1:0]  duty_lo,
  input  logic [NT-1:0]  ticks,
  output logic           out_hi,
  output logic           out_lo
);
  logic out_lo8;
  logic out_cat;

  pwm_mux_chan #(.W(CW)) u_hi (
    .clk(clk), .rst(rst), .en(en_hi && !cat), .tick(ticks[sel_hi]),
    .per_in(per_hi), .duty_in(duty_hi), .pwm_o(out_hi)
  );

  pwm_mux_chan #(.W(CW)) u_lo (
    .clk(clk), .rst(rst), .en(en_lo && !cat), .tick(ticks[sel_lo]),
    .per_in(per_lo), .duty_in(duty_lo), .pwm_o(out_lo8)
  );

  pwm_mux_chan #(.W(2*CW)) u_cat (
    .clk(clk), .rst(rst), .en(en_lo && cat), .tick(ticks[sel_lo]),
    .per_in({per_hi, per_lo}), .duty_in({duty_hi, duty_lo}), .pwm_o(out_cat)
  );

  assign out_lo = out_lo8 | out_cat;

  AST_CAT_HI_OFF: assert property (@(posedge clk) disable iff (rst)
    (cat && $past(cat)) |=> !out_hi); // R9
endmodule

// File: rtl/pwm_mux8.sv
module pwm_mux8
  import pwm_mux_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 8,
  parameter int PSW = 3,
  localparam int CHW = $clog2(NCH),
  localparam int AW  = CHW + 2,
  localparam int NT  = 2 ** PSW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  input  logic           bus_we,
  output logic [CW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  logic [NCH-1:0]            en_q;
  logic [NCH/2-1:0]          cat_q;
  logic [NCH-1:0][PSW-1:0]   sel_q;
  logic [NCH-1:0][CW-1:0]    per_q;
  logic [NCH-1:0][CW-1:0]    duty_q;
  logic [NT-1:0]             ticks;

  pwm_mux_regs #(.NCH(NCH), .CW(CW), .PSW(PSW)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .rdata(bus_rdata), .en_q(en_q), .cat_q(cat_q), .sel_o(sel_q),
    .per_q(per_q), .duty_q(duty_q)
  );

  pwm_mux_prescale #(.PSW(PSW)) u_pre (
    .clk(clk), .rst(rst), .run(|en_q), .tick(ticks)
  );

  for (genvar p = 0; p < NCH/2; p++) begin : g_pair
    pwm_mux_pair #(.CW(CW), .PSW(PSW)) u_pair (
      .clk(clk), .rst(rst), .cat(cat_q[p]),
      .en_hi(en_q[2*p]), .en_lo(en_q[2*p+1]),
      .sel_hi(sel_q[2*p]), .sel_lo(sel_q[2*p+1]),
      .per_hi(per_q[2*p]), .per_lo(per_q[2*p+1]),
      .duty_hi(duty_q[2*p]), .duty_lo(duty_q[2*p+1]),
      .ticks(ticks),
      .out_hi(pwm_out[2*p]), .out_lo(pwm_out[2*p+1])
    );
  end
endmodule

// File: tb/pwm_mux8_tb_top.sv
module pwm_mux8_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic [7:0] pout;
  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_mux8 dut_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_rdata(rdata), .pwm_out(pout)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); v = rdata;
  endtask

  task automatic sample(input int len, output int h [8]);
    for (int i = 0; i < 8; i++) h[i] = 0;
    repeat (len) begin
      @(negedge clk);
      for (int i = 0; i < 8; i++) if (pout[i]) h[i]++;
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int v;
    int h [8];
    int idx;
    int n;
    bit go;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(5'h00, v); chk("R1 enable", v, 0);
    rd(5'h15, v); chk("R1 period5", v, 0);
    rd(5'h1B, v); chk("R1 duty3", v, 0);
    chk("R1 pins", pout, 0);

    // R2 register map and readback
    wr(5'h0E, 8'hF5); rd(5'h0E, v); chk("R2 clksel6", v, 'hF5);
    wr(5'h17, 8'h3C); rd(5'h17, v); chk("R2 period7", v, 'h3C);
    wr(5'h18, 8'h81); rd(5'h18, v); chk("R2 duty0", v, 'h81);
    wr(5'h01, 8'h0A); rd(5'h01, v); chk("R2 concat", v, 'h0A);
    wr(5'h00, 8'hA5); rd(5'h00, v); chk("R2 enable", v, 'hA5);
    rd(5'h02, v); chk("R2 unmapped", v, 0);
    wr(5'h00, 8'h00); wr(5'h01, 8'h00);

    // R3/R4 sweep on channel 2
    for (int s = 0; s < 3; s++) begin
      for (int pi = 0; pi < 5; pi++) begin
        int P;
        int d;
        P = (pi == 0) ? 1 : (pi == 1) ? 2 : (pi == 2) ? 3 : (pi == 3) ? 5 : 8;
        d = 1 << s;
        for (int D = 0; D <= P + 1; D++) begin
          wr(5'h00, 8'h00);
          wr(5'h0A, 8'(s)); wr(5'h12, 8'(P)); wr(5'h1A, 8'(D));
          wr(5'h00, 8'h04);
          repeat (2 * d + 4) @(negedge clk);
          sample(2 * P * d, h);
          chk("R3/R4 sweep", h[2], 2 * imin(D, P) * d);
          chk("R5 idle pin", h[3], 0);
        end
      end
    end

    // R4 period zero means 256 ticks
    wr(5'h00, 8'h00);
    wr(5'h0A, 8'd0); wr(5'h12, 8'd0); wr(5'h1A, 8'd100);
    wr(5'h00, 8'h04);
    repeat (6) @(negedge clk);
    sample(512, h); chk("R4 period0", h[2], 200);

    // R6 start-up latency with select 7
    wr(5'h00, 8'h00);
    wr(5'h09, 8'd7); wr(5'h11, 8'd4); wr(5'h19, 8'd4);
    wr(5'h00, 8'h02);
    idx = 0;
    while (!pout[1] && idx < 400) begin @(negedge clk); idx++; end
    chk("R6 latency", idx, 129);

    // R5 disabled pin low
    wr(5'h00, 8'h00);
    repeat (2) @(negedge clk);
    sample(60, h); chk("R5 off", h[1], 0);

    // R7 divider idle: same latency after an odd gap
    repeat (37) @(negedge clk);
    wr(5'h00, 8'h02);
    idx = 0;
    while (!pout[1] && idx < 400) begin @(negedge clk); idx++; end
    chk("R7 latency repeat", idx, 129);

    // R10 mid-period duty write on channel 3
    wr(5'h00, 8'h00);
    wr(5'h0B, 8'd0); wr(5'h13, 8'd10); wr(5'h1B, 8'd5);
    wr(5'h00, 8'h08);
    repeat (30) @(negedge clk);
    while (pout[3]) @(negedge clk);
    while (!pout[3]) @(negedge clk);
    addr = 5'h1B; wdata = 8'd2; we = 1'b1;
    n = 1; go = 1'b1;
    while (go) begin
      @(negedge clk); we = 1'b0;
      if (pout[3]) n++; else go = 1'b0;
    end
    chk("R10 old duty kept", n, 5);
    while (!pout[3]) @(negedge clk);
    n = 0;
    while (pout[3]) begin n++; @(negedge clk); end
    chk("R10 new duty", n, 2);

    // R8/R9 concatenated pair 4,5: period 300
    wr(5'h00, 8'h00);
    wr(5'h01, 8'h04);
    wr(5'h0C, 8'd3); wr(5'h0D, 8'd1);
    wr(5'h14, 8'd1); wr(5'h15, 8'd44);
    for (int k = 0; k < 5; k++) begin
      int D16;
      D16 = (k == 0) ? 0 : (k == 1) ? 100 : (k == 2) ? 299 : (k == 3) ? 300 : 400;
      wr(5'h00, 8'h00);
      wr(5'h1C, 8'(D16 >> 8)); wr(5'h1D, 8'(D16 & 255));
      wr(5'h00, 8'h30);
      repeat (8) @(negedge clk);
      sample(1200, h);
      chk("R8 joined waveform", h[5], 4 * imin(D16, 300));
      chk("R9 even pin low", h[4], 0);
    end
    wr(5'h00, 8'h10);
    repeat (4) @(negedge clk);
    sample(300, h);
    chk("R9 even enable ignored", h[4], 0);
    chk("R8 odd enable off", h[5], 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule